// File: doc/BRIEF.md
# Trigger Accept Gating Controller

This block sits between the level-1 trigger decision logic and the sender that transmits accept commands to the readout crates. Every clock cycle it samples a trigger pulse. It either turns that pulse into an accept strobe or drops it. A trigger is dropped when any of three conditions holds: an external inhibit is raised, the front-end buffers report that no slot is free, or the hold-off window that follows the previous accept is still running. A dropped trigger is discarded and is never replayed later.

Each accept carries two stamps. The first is a rolling 5-bit sequence tag. The second is a 56-bit event key taken from a free-running count of system clocks. The block also keeps a separate saturating counter for each suppression cause, so the dead time can be split by reason. The hold-off length is an input in clock cycles. At a 125 MHz clock, a value of about 260 gives the nominal window of slightly over 2 µs.

Top module: `trig_accept_gate`

## Requirements
- R1: When `trig_i` is sampled high at a clock edge and none of inhibit, full or busy holds, `accept_o` is high for exactly the one cycle that follows that edge. Otherwise `accept_o` stays low.
- R2: Suppose an accept is issued at edge E while `holdoff_i` equals H. Then a trigger at any of the edges E+1 through E+H is suppressed as busy, and a trigger at edge E+H+1 can be accepted. H = 0 allows accepts on consecutive edges.
- R3: While `full_i` is high, no trigger is accepted.
- R4: While `inhibit_i` is high, no trigger is accepted.
- R5: `tag_o` is 0 on the first accept after reset. It rises by one on each later accept and wraps from 31 to 0. Between accepts it holds its value.
- R6: An internal 56-bit clock count is 0 at the first edge after reset and rises by one at every edge. On an accept, `key_o` takes the count value of the accepting edge and holds it until the next accept.
- R7: Each suppressed trigger adds one to exactly one counter. The cause is chosen by priority: inhibit (`rej_inhibit_o`) first, then full (`rej_full_o`), then busy (`rej_busy_o`).
- R8: A rejection counter that reaches its all-ones value stays there. It does not wrap.
- R9: A suppressed trigger is discarded. No accept is produced from it later, even after every blocking condition clears.
- R10: While reset is active and right after it, `accept_o`, `tag_o`, `key_o` and all rejection counters read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Level-1 trigger pulse, one per cycle at most |
| full_i | input | 1 | High when no front-end buffer slot is free |
| inhibit_i | input | 1 | External inhibit, blocks all accepts |
| holdoff_i | input | HOLD_W (12) | Busy window length in cycles after each accept |
| accept_o | output | 1 | One-cycle accept strobe |
| tag_o | output | TAG_W (5) | Sequence tag of the latest accept |
| key_o | output | KEY_W (56) | Clock-count event key of the latest accept |
| rej_busy_o | output | CNT_W (16) | Triggers suppressed because of the hold-off window |
| rej_full_o | output | CNT_W (16) | Triggers suppressed because the buffers are full |
| rej_inhibit_o | output | CNT_W (16) | Triggers suppressed by the inhibit |

## Verification
The bench first sends isolated triggers that are spaced well beyond the hold-off window. These confirm the plain accept path, including the tag and key stamps. Next it sends an unbroken train of triggers against a 10-cycle window, which checks the exact edge at which busy ends. It then sends triggers under full only, and then under inhibit and full together, to show that the priority puts each suppressed trigger in the right counter. A long train with zero hold-off makes the tag wrap and shows that back-to-back accepts work. A final train against a long window drives the busy counter past its limit, which shows that it saturates and that the discarded triggers never come back as accepts.

// File: rtl/trig_gate_pkg.sv
package trig_gate_pkg;

    // Outcome of one sampled trigger
    typedef enum logic [1:0] {
        RSN_NONE    = 2'd0,
        RSN_BUSY    = 2'd1,
        RSN_FULL    = 2'd2,
        RSN_INHIBIT = 2'd3
    } reject_e;

endpackage

// File: rtl/trig_reject_classify.sv
module trig_reject_classify
    import trig_gate_pkg::*;
(
    input  logic    trig_i,
    input  logic    busy_i,
    input  logic    full_i,
    input  logic    inhibit_i,
    output logic    issue_o,
    output reject_e reason_o
);

    always_comb begin
        issue_o  = 1'b0;
        reason_o = RSN_NONE;
        if (trig_i) begin
            if (inhibit_i) begin
                reason_o = RSN_INHIBIT;
            end else if (full_i) begin
                reason_o = RSN_FULL;
            end else if (busy_i) begin
                reason_o = RSN_BUSY;
            end else begin
                issue_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/holdoff_timer.sv
module holdoff_timer #(
    parameter int HOLD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [HOLD_W-1:0] len_i,
    output logic              busy_o
);

    logic [HOLD_W-1:0] remain_d, remain_q;

    always_comb begin
        remain_d = remain_q;
        if (load_i) begin
            remain_d = len_i;
        end else if (remain_q != '0) begin
            remain_d = remain_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) remain_q <= '0;
        else        remain_q <= remain_d;
    end

    assign busy_o = (remain_q != '0);

    // R2
    holdoff_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && len_i != '0) |=> busy_o);

    // R2
    holdoff_no_load_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !load_i);

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (inc_i && count_q != CNT_MAX) count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = count_q;

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CNT_MAX) |=> (count_o == CNT_MAX));

    // R7
    sat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != CNT_MAX) |=> (count_o == $past(count_o) + CNT_W'(1)) || $stable(count_o));

endmodule

// File: rtl/trig_accept_gate.sv
module trig_accept_gate
    import trig_gate_pkg::*;
#(
    parameter int HOLD_W = 12,
    parameter int TAG_W  = 5,
    parameter int KEY_W  = 56,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              full_i,
    input  logic              inhibit_i,
    input  logic [HOLD_W-1:0] holdoff_i,
    output logic              accept_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [KEY_W-1:0]  key_o,
    output logic [CNT_W-1:0]  rej_busy_o,
    output logic [CNT_W-1:0]  rej_full_o,
    output logic [CNT_W-1:0]  rej_inhibit_o
);

    localparam int NUM_RSN = 3;

    typedef struct packed {
        logic             accept;
        logic [TAG_W-1:0] tag;
        logic [TAG_W-1:0] next_tag;
        logic [KEY_W-1:0] key;
        logic [KEY_W-1:0] clk_cnt;
    } gate_state_t;

    gate_state_t st_d, st_q;

    logic                busy;
    logic                issue;
    reject_e             reason;
    logic [NUM_RSN-1:0]  rej_inc;
    logic [CNT_W-1:0]    rej_cnt [NUM_RSN];

    trig_reject_classify u_classify (
        .trig_i    (trig_i),
        .busy_i    (busy),
        .full_i    (full_i),
        .inhibit_i (inhibit_i),
        .issue_o   (issue),
        .reason_o  (reason)
    );

    holdoff_timer #(.HOLD_W(HOLD_W)) u_holdoff (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (issue),
        .len_i  (holdoff_i),
        .busy_o (busy)
    );

    // index 0 = busy, 1 = full, 2 = inhibit
    assign rej_inc[0] = (reason == RSN_BUSY);
    assign rej_inc[1] = (reason == RSN_FULL);
    assign rej_inc[2] = (reason == RSN_INHIBIT);

    for (genvar gi = 0; gi < NUM_RSN; gi++) begin : g_rej
        sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (rej_inc[gi]),
            .count_o (rej_cnt[gi])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.accept  = 1'b0;
        st_d.clk_cnt = st_q.clk_cnt + 1'b1;
        if (issue) begin
            st_d.accept   = 1'b1;
            st_d.tag      = st_q.next_tag;
            st_d.next_tag = st_q.next_tag + 1'b1;
            st_d.key      = st_q.clk_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign accept_o      = st_q.accept;
    assign tag_o         = st_q.tag;
    assign key_o         = st_q.key;
    assign rej_busy_o    = rej_cnt[0];
    assign rej_full_o    = rej_cnt[1];
    assign rej_inhibit_o = rej_cnt[2];

    // R1
    accept_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> $past(trig_i));

    // R2
    accept_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> !$past(busy));

    // R3
    accept_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> !$past(full_i));

    // R4
    accept_not_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> !$past(inhibit_i));

    // R5
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tag_o) |-> accept_o);

    // R6
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key_o) |-> accept_o);

    // R7
    one_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rej_inc) && !(issue && rej_inc != '0));

endmodule

// File: tb/tb_trig_accept_gate.sv
module tb_trig_accept_gate;

    localparam int HOLD_W = 12;
    localparam int TAG_W  = 5;
    localparam int KEY_W  = 56;
    localparam int CNT_W  = 4;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig_i = 1'b0;
    logic              full_i = 1'b0;
    logic              inhibit_i = 1'b0;
    logic [HOLD_W-1:0] holdoff_i = '0;
    logic              accept_o;
    logic [TAG_W-1:0]  tag_o;
    logic [KEY_W-1:0]  key_o;
    logic [CNT_W-1:0]  rej_busy_o, rej_full_o, rej_inhibit_o;

    trig_accept_gate #(.HOLD_W(HOLD_W), .TAG_W(TAG_W), .KEY_W(KEY_W), .CNT_W(CNT_W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig_i        (trig_i),
        .full_i        (full_i),
        .inhibit_i     (inhibit_i),
        .holdoff_i     (holdoff_i),
        .accept_o      (accept_o),
        .tag_o         (tag_o),
        .key_o         (key_o),
        .rej_busy_o    (rej_busy_o),
        .rej_full_o    (rej_full_o),
        .rej_inhibit_o (rej_inhibit_o)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [TAG_W-1:0] tag;
        logic [KEY_W-1:0] key;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    longint edge_idx = 0;
    always @(posedge clk) if (rst_n) edge_idx <= edge_idx + 1;

    // reference model state
    int     m_tag = 0;
    bit     m_have_acc = 1'b0;
    longint m_last_edge = 0;
    int     m_last_hold = 0;
    int     m_busy = 0, m_full = 0, m_inh = 0;

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat(int v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    // driver: one trigger for the coming edge, called right after a negedge
    task automatic fire();
        longint idx;
        exp_t   e;
        idx = edge_idx;
        trig_i = 1'b1;
        if (inhibit_i) m_inh = sat(m_inh);
        else if (full_i) m_full = sat(m_full);
        else if (m_have_acc && (idx - m_last_edge) <= m_last_hold) m_busy = sat(m_busy);
        else begin
            e.tag = TAG_W'(m_tag);
            e.key = KEY_W'(idx);
            exp_q.push_back(e);
            m_tag = (m_tag + 1) % 32;
            m_have_acc = 1'b1;
            m_last_edge = idx;
            m_last_hold = int'(holdoff_i);
        end
        @(negedge clk);
        trig_i = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_counters(string req);
        check(rej_busy_o == CNT_W'(m_busy), {req, " busy count"}, rej_busy_o, m_busy);
        check(rej_full_o == CNT_W'(m_full), {req, " full count"}, rej_full_o, m_full);
        check(rej_inhibit_o == CNT_W'(m_inh), {req, " inhibit count"}, rej_inhibit_o, m_inh);
    endtask

    // monitor: compares each accept with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && accept_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected accept", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(tag_o == e.tag, "R5 tag", tag_o, e.tag);
                check(key_o == e.key, "R6 key", key_o, e.key);
            end
        end
    end

    initial begin
        #(200000 * 8);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(accept_o == 1'b0, "R10 accept", accept_o, 0);
        check(tag_o == '0, "R10 tag", tag_o, 0);
        check(key_o == '0, "R10 key", key_o, 0);
        check_counters("R10");
        rst_n = 1'b1;
        idle(2);

        // R1 isolated triggers, R2 window of 10
        holdoff_i = 12'd10;
        fire();
        idle(20);
        fire();
        idle(20);
        // R2 continuous train: edges E+1..E+10 busy, E+11 accepted
        for (int i = 0; i < 15; i++) fire();
        idle(20);
        check_counters("R2");

        // R3 full only
        full_i = 1'b1;
        for (int i = 0; i < 3; i++) begin fire(); idle(15); end
        // R4 and R7 inhibit over full
        inhibit_i = 1'b1;
        for (int i = 0; i < 3; i++) begin fire(); idle(15); end
        full_i = 1'b0;
        fire();
        idle(15);
        inhibit_i = 1'b0;
        idle(3);
        check_counters("R7");
        check(accept_o == 1'b0, "R9 no late accept", accept_o, 0);

        // R5 wrap with zero hold-off, back-to-back accepts
        idle(15);
        holdoff_i = 12'd0;
        for (int i = 0; i < 40; i++) fire();
        idle(3);

        // R8 saturation of busy counter
        holdoff_i = 12'd30;
        for (int i = 0; i < 25; i++) fire();
        idle(40);
        check_counters("R8");
        check(exp_q.size() == 0, "R9 pending accepts", exp_q.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule